// File: doc/BRIEF.md
# Power-of-Two Region Window Allocator

This block turns one address region into a run of translation windows, each a power of two in size and aligned to its own size. A request gives a physical start, a bus start, a byte size, an action word and the index of the first free window. While it runs, the engine sends out one window programming record per clock cycle. Each record holds the window index, the match address, the remap address, the mask and the action word. The record stream is meant to feed the register port of an address translator.

Each step takes the largest chunk that fits in the remaining size and that is also aligned to the current physical start. Allocation stops in one of three cases: the region is fully covered, the window budget runs out, or the next aligned chunk would be smaller than the minimum window size. When the engine finishes, it reports the next free index, whether that index is still valid, and where the range of windows to disable begins. Requests can be chained: the reported index and its valid bit go straight into the next request, so a failed region makes every later request do nothing.

Top module: `pow2_window_alloc`

## Requirements
- R1: The chunk for each record is the smaller of (a) the highest power of two that does not exceed the remaining size and (b) the lowest set bit of the current physical start. A physical start of zero places no alignment limit.
- R2: Each record carries match = current physical start, remap = current bus start, action = the request's action word, and mask = bitwise NOT of (chunk − 1) with bits [15:0] forced to zero.
- R3: After a record, the physical start and the bus start both grow by the chunk, the remaining size shrinks by the chunk, and the next record's index is one higher.
- R4: Only indices 0 to 7 are ever emitted. Allocation stops as soon as the index reaches 8, and a start index of 8 or more emits nothing.
- R5: If the chunk would be smaller than 0x10000 bytes, no record is emitted and allocation stops.
- R6: If any size is left when allocation stops, fail is 1, next_idx_ok is 0 and next_idx is 0.
- R7: A request with first_idx_ok = 0 emits no records. It ends with fail = 0, next_idx_ok = 0 and next_idx = 0.
- R8: A request of size zero emits no records. It ends with fail = 0, next_idx_ok = 1 and next_idx = first_idx.
- R9: disable_from equals next_idx when next_idx_ok is 1, and equals 0 otherwise.
- R10: When start is seen while busy is low, busy goes high on the next cycle. Records then follow on consecutive cycles. done is a one-cycle pulse in the cycle after the last record, and the result outputs hold their values until the next request ends.
- R11: A start pulse while busy is high is ignored and has no effect on the records or the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted only when idle |
| first_idx | input | 4 | First free window index |
| first_idx_ok | input | 1 | First index is valid |
| phys_start | input | 64 | Physical start of the region |
| bus_start | input | 64 | Bus start of the region |
| region_size | input | 64 | Region size in bytes |
| action | input | 32 | Action word copied into every record |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Last request left part of its region uncovered |
| next_idx | output | 4 | Next free window index |
| next_idx_ok | output | 1 | next_idx is valid |
| disable_from | output | 4 | First window index to disable |
| rec_valid | output | 1 | Record strobe |
| rec_idx | output | 4 | Record window index |
| rec_match | output | 64 | Record match address |
| rec_remap | output | 64 | Record remap address |
| rec_mask | output | 64 | Record mask |
| rec_action | output | 32 | Record action word |

## Verification
The properties check these on every cycle: emitted indices stay under the budget, every match is aligned to its own mask, and back-to-back records step by one index and by exactly the previous chunk. They also check that done is a single pulse, that a failure always clears the index valid bit, and that the disable start falls back to zero. Only the bench scenarios can show that a chunk is the largest legal one and that the right stop cause takes effect. The scenarios cover a misaligned start, a region that needs more than eight windows, a too-small alignment, chained requests, zero size, an invalid index, and a start pulse during a run.

// File: rtl/pow2_alloc_pkg.sv
package pow2_alloc_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } alloc_state_e;

   typedef enum logic [1:0] {
      END_NONE  = 2'd0,
      END_CLEAN = 2'd1,
      END_SHORT = 2'd2,
      END_VOID  = 2'd3
   } alloc_end_e;

endpackage

// File: rtl/pow2_lead_detect.sv
module pow2_lead_detect #(
   parameter int W = 64
) (
   input  logic [W-1:0] vec,
   output logic [W-1:0] onehot
);
   logic [W:0] seen_above;

   assign seen_above[W] = 1'b0;

   generate
      for (genvar i = W - 1; i >= 0; i--) begin : g_bit
         assign seen_above[i] = seen_above[i+1] | vec[i];
         assign onehot[i]     = vec[i] & ~seen_above[i+1];
      end
   endgenerate
endmodule

// File: rtl/pow2_trail_detect.sv
module pow2_trail_detect #(
   parameter int W         = 64,
   parameter bit USE_ARITH = 1'b1
) (
   input  logic [W-1:0] vec,
   output logic [W-1:0] onehot
);
   generate
      if (USE_ARITH) begin : g_arith
         assign onehot = vec & (~vec + {{(W-1){1'b0}}, 1'b1});
      end else begin : g_chain
         logic [W:0] seen_below;
         assign seen_below[0] = 1'b0;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign seen_below[i+1] = seen_below[i] | vec[i];
            assign onehot[i]       = vec[i] & ~seen_below[i];
         end
      end
   endgenerate
endmodule

// File: rtl/pow2_chunk_step.sv
module pow2_chunk_step #(
   parameter int ADDR_W      = 64,
   parameter int MIN_SHIFT   = 16,
   parameter bit TRAIL_ARITH = 1'b1
) (
   input  logic [ADDR_W-1:0] cur_phys,
   input  logic [ADDR_W-1:0] cur_left,
   output logic [ADDR_W-1:0] chunk,
   output logic [ADDR_W-1:0] chunk_mask,
   output logic              too_small
);
   localparam logic [ADDR_W-1:0] MIN_CHUNK = ADDR_W'(1) << MIN_SHIFT;
   localparam logic [ADDR_W-1:0] LOW_CLEAR = ~(MIN_CHUNK - ADDR_W'(1));

   logic [ADDR_W-1:0] size_cap;
   logic [ADDR_W-1:0] align_cap;
   logic              unaligned_free;

   pow2_lead_detect #(.W(ADDR_W)) u_lead (
      .vec    (cur_left),
      .onehot (size_cap)
   );

   pow2_trail_detect #(.W(ADDR_W), .USE_ARITH(TRAIL_ARITH)) u_trail (
      .vec    (cur_phys),
      .onehot (align_cap)
   );

   assign unaligned_free = (cur_phys == '0);

   always_comb begin
      if (unaligned_free || (size_cap < align_cap)) begin
         chunk = size_cap;
      end else begin
         chunk = align_cap;
      end
   end

   assign chunk_mask = ~(chunk - ADDR_W'(1)) & LOW_CLEAR;
   assign too_small  = (chunk < MIN_CHUNK);
endmodule

// File: rtl/pow2_window_alloc.sv
module pow2_window_alloc #(
   parameter int ADDR_W      = 64,
   parameter int ACT_W       = 32,
   parameter int WIN_COUNT   = 8,
   parameter int MIN_SHIFT   = 16,
   parameter bit TRAIL_ARITH = 1'b1,
   localparam int IDX_W      = $clog2(WIN_COUNT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [IDX_W-1:0]  first_idx,
   input  logic              first_idx_ok,
   input  logic [ADDR_W-1:0] phys_start,
   input  logic [ADDR_W-1:0] bus_start,
   input  logic [ADDR_W-1:0] region_size,
   input  logic [ACT_W-1:0]  action,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [IDX_W-1:0]  next_idx,
   output logic              next_idx_ok,
   output logic [IDX_W-1:0]  disable_from,
   output logic              rec_valid,
   output logic [IDX_W-1:0]  rec_idx,
   output logic [ADDR_W-1:0] rec_match,
   output logic [ADDR_W-1:0] rec_remap,
   output logic [ADDR_W-1:0] rec_mask,
   output logic [ACT_W-1:0]  rec_action
);
   import pow2_alloc_pkg::*;

   localparam logic [IDX_W-1:0] IDX_LIMIT = IDX_W'(WIN_COUNT);

   generate
      if (MIN_SHIFT >= ADDR_W) begin : g_bad_shift
         $error("MIN_SHIFT must be below ADDR_W");
      end
      if (WIN_COUNT < 1) begin : g_bad_count
         $error("WIN_COUNT must be at least one");
      end
      if (ADDR_W < 2) begin : g_bad_width
         $error("ADDR_W too small");
      end
   endgenerate

   alloc_state_e      st_q;
   logic [ADDR_W-1:0] phys_q;
   logic [ADDR_W-1:0] bus_q;
   logic [ADDR_W-1:0] left_q;
   logic [ACT_W-1:0]  act_q;
   logic [IDX_W-1:0]  idx_q;
   logic              idx_ok_q;

   logic [ADDR_W-1:0] step_chunk;
   logic [ADDR_W-1:0] step_mask;
   logic              step_small;
   logic              budget_gone;
   alloc_end_e        end_kind;

   pow2_chunk_step #(
      .ADDR_W      (ADDR_W),
      .MIN_SHIFT   (MIN_SHIFT),
      .TRAIL_ARITH (TRAIL_ARITH)
   ) u_step (
      .cur_phys   (phys_q),
      .cur_left   (left_q),
      .chunk      (step_chunk),
      .chunk_mask (step_mask),
      .too_small  (step_small)
   );

   assign budget_gone = (idx_q >= IDX_LIMIT);

   always_comb begin
      if (!idx_ok_q) begin
         end_kind = END_VOID;
      end else if (left_q == '0) begin
         end_kind = END_CLEAN;
      end else if (budget_gone || step_small) begin
         end_kind = END_SHORT;
      end else begin
         end_kind = END_NONE;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         phys_q      <= '0;
         bus_q       <= '0;
         left_q      <= '0;
         act_q       <= '0;
         idx_q       <= '0;
         idx_ok_q    <= 1'b0;
         done        <= 1'b0;
         fail        <= 1'b0;
         next_idx    <= '0;
         next_idx_ok <= 1'b0;
         rec_valid   <= 1'b0;
         rec_idx     <= '0;
         rec_match   <= '0;
         rec_remap   <= '0;
         rec_mask    <= '0;
         rec_action  <= '0;
      end else begin
         rec_valid <= 1'b0;
         done      <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  phys_q   <= phys_start;
                  bus_q    <= bus_start;
                  left_q   <= region_size;
                  act_q    <= action;
                  idx_q    <= first_idx;
                  idx_ok_q <= first_idx_ok;
                  st_q     <= ST_RUN;
               end
            end
            ST_RUN: begin
               case (end_kind)
                  END_VOID: begin
                     done        <= 1'b1;
                     fail        <= 1'b0;
                     next_idx    <= '0;
                     next_idx_ok <= 1'b0;
                     st_q        <= ST_IDLE;
                  end
                  END_CLEAN: begin
                     done        <= 1'b1;
                     fail        <= 1'b0;
                     next_idx    <= idx_q;
                     next_idx_ok <= 1'b1;
                     st_q        <= ST_IDLE;
                  end
                  END_SHORT: begin
                     done        <= 1'b1;
                     fail        <= 1'b1;
                     next_idx    <= '0;
                     next_idx_ok <= 1'b0;
                     st_q        <= ST_IDLE;
                  end
                  default: begin
                     rec_valid  <= 1'b1;
                     rec_idx    <= idx_q;
                     rec_match  <= phys_q;
                     rec_remap  <= bus_q;
                     rec_mask   <= step_mask;
                     rec_action <= act_q;
                     phys_q     <= phys_q + step_chunk;
                     bus_q      <= bus_q + step_chunk;
                     left_q     <= left_q - step_chunk;
                     idx_q      <= idx_q + IDX_W'(1);
                  end
               endcase
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy         = (st_q == ST_RUN);
   assign disable_from = next_idx_ok ? next_idx : '0;
endmodule

// File: rtl/pow2_window_alloc_chk.sv
module pow2_window_alloc_chk #(
   parameter int ADDR_W    = 64,
   parameter int WIN_COUNT = 8,
   parameter int MIN_SHIFT = 16,
   parameter int IDX_W     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              fail,
   input logic              next_idx_ok,
   input logic [IDX_W-1:0]  disable_from,
   input logic              rec_valid,
   input logic [IDX_W-1:0]  rec_idx,
   input logic [ADDR_W-1:0] rec_match,
   input logic [ADDR_W-1:0] rec_mask
);
   p_idx_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> (rec_idx < IDX_W'(WIN_COUNT)));

   p_match_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> ((rec_match & ~rec_mask) == '0));

   p_mask_low_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> (rec_mask[MIN_SHIFT-1:0] == '0));

   p_idx_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && $past(rec_valid)) |-> ((rec_idx - $past(rec_idx)) == IDX_W'(1)));

   p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_valid && $past(rec_valid)) |->
         ((rec_match - $past(rec_match)) == (~$past(rec_mask) + ADDR_W'(1))));

   p_fail_drops_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fail) |-> !next_idx_ok);

   p_disable_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !next_idx_ok |-> (disable_from == '0));

   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_not_rec_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !rec_valid);

   p_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
endmodule

bind pow2_window_alloc pow2_window_alloc_chk #(
   .ADDR_W    (ADDR_W),
   .WIN_COUNT (WIN_COUNT),
   .MIN_SHIFT (MIN_SHIFT),
   .IDX_W     (IDX_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .busy         (busy),
   .done         (done),
   .fail         (fail),
   .next_idx_ok  (next_idx_ok),
   .disable_from (disable_from),
   .rec_valid    (rec_valid),
   .rec_idx      (rec_idx),
   .rec_match    (rec_match),
   .rec_mask     (rec_mask)
);

// File: tb/pow2_window_alloc_test.sv
module pow2_window_alloc_test;
   typedef struct {
      logic [3:0]  idx;
      logic [63:0] match;
      logic [63:0] remap;
      logic [63:0] mask;
      logic [31:0] act;
   } rec_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  first_idx = '0;
   logic        first_idx_ok = 1'b0;
   logic [63:0] phys_start = '0;
   logic [63:0] bus_start = '0;
   logic [63:0] region_size = '0;
   logic [31:0] action = '0;
   logic        busy, done, fail, next_idx_ok, rec_valid;
   logic [3:0]  next_idx, disable_from, rec_idx;
   logic [63:0] rec_match, rec_remap, rec_mask;
   logic [31:0] rec_action;

   int checks = 0;
   int failures = 0;
   rec_t expq[$];

   always #5 clk = ~clk;

   pow2_window_alloc uut (
      .clk(clk), .rst_n(rst_n), .start(start), .first_idx(first_idx),
      .first_idx_ok(first_idx_ok), .phys_start(phys_start), .bus_start(bus_start),
      .region_size(region_size), .action(action), .busy(busy), .done(done),
      .fail(fail), .next_idx(next_idx), .next_idx_ok(next_idx_ok),
      .disable_from(disable_from), .rec_valid(rec_valid), .rec_idx(rec_idx),
      .rec_match(rec_match), .rec_remap(rec_remap), .rec_mask(rec_mask),
      .rec_action(rec_action)
   );

   task automatic check(string req, logic [63:0] got, logic [63:0] want);
      checks++;
      if (got !== want) begin
         failures++;
         $display("FAIL %s got=%h exp=%h", req, got, want);
      end
   endtask

   function automatic logic [63:0] top_bit(logic [63:0] v);
      logic [63:0] r = '0;
      for (int i = 0; i < 64; i++) if (v[i]) r = 64'd1 << i;
      return r;
   endfunction

   function automatic logic [63:0] low_bit(logic [63:0] v);
      logic [63:0] r = '0;
      for (int i = 63; i >= 0; i--) if (v[i]) r = 64'd1 << i;
      return r;
   endfunction

   // monitor: pops one expected record per strobe (R1 R2 R3 R4)
   always @(negedge clk) begin
      if (rst_n && rec_valid) begin
         if (expq.size() == 0) begin
            check("R4 unexpected record", {60'd0, rec_idx}, 64'hffff);
         end else begin
            rec_t e;
            e = expq.pop_front();
            check("R4 rec idx", {60'd0, rec_idx}, {60'd0, e.idx});
            check("R1 R2 rec match", rec_match, e.match);
            check("R3 rec remap", rec_remap, e.remap);
            check("R2 rec mask", rec_mask, e.mask);
            check("R2 rec action", {32'd0, rec_action}, {32'd0, e.act});
         end
      end
   end

   task automatic run_case(string name, logic [63:0] ph, logic [63:0] bu,
                           logic [63:0] sz, logic [3:0] fi, logic fok, bit poke);
      logic [63:0] p = ph, b = bu, r = sz, c;
      logic [3:0]  i = fi;
      logic        e_fail = 1'b0, e_ok = 1'b0;
      logic [3:0]  e_next = '0;
      int          wait_n = 0;
      if (fok) begin
         forever begin
            if (r == 0) begin e_ok = 1'b1; e_next = i; break; end
            if (i >= 4'd8) begin e_fail = 1'b1; break; end
            c = top_bit(r);
            if (p != 0 && low_bit(p) < c) c = low_bit(p);
            if (c < 64'h10000) begin e_fail = 1'b1; break; end
            expq.push_back('{i, p, b, ~(c - 64'd1) & ~64'hffff, 32'hA5A50000 + sz[31:0]});
            p = p + c; b = b + c; r = r - c; i = i + 4'd1;
         end
      end
      @(negedge clk);
      phys_start = ph; bus_start = bu; region_size = sz; first_idx = fi;
      first_idx_ok = fok; action = 32'hA5A50000 + sz[31:0]; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check({"R10 busy after start ", name}, {63'd0, busy}, 64'd1);
      if (poke) begin
         // R11: second start while busy, with different inputs
         phys_start = 64'h1234_0000; region_size = 64'h10000; first_idx = 4'd3;
         action = 32'hdead; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done && wait_n < 1000) begin
         @(negedge clk);
         wait_n++;
      end
      check({"R10 done seen ", name}, {63'd0, done}, 64'd1);
      check({"R10 R11 records drained ", name}, expq.size(), 64'd0);
      expq.delete();
      check({"R6 fail ", name}, {63'd0, fail}, {63'd0, e_fail});
      check({"R6 R7 R8 next ok ", name}, {63'd0, next_idx_ok}, {63'd0, e_ok});
      check({"R6 R7 R8 next idx ", name}, {60'd0, next_idx}, {60'd0, e_next});
      check({"R9 disable from ", name}, {60'd0, disable_from},
            {60'd0, (e_ok ? e_next : 4'd0)});
      @(negedge clk);
      check({"R10 done pulse ", name}, {63'd0, done}, 64'd0);
      check({"R10 held result ", name}, {63'd0, fail}, {63'd0, e_fail});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 reset busy", {63'd0, busy}, 64'd0);
      check("R10 reset done", {63'd0, done}, 64'd0);
      check("R10 reset rec", {63'd0, rec_valid}, 64'd0);
      // R1 R3: misaligned-size region at a large aligned start, then chained
      run_case("io", 64'hefff0000, 64'h0, 64'h10000, 4'd0, 1'b1, 1'b0);
      run_case("mem", 64'he8000000, 64'h4000_0000, 64'h7f00000, 4'd1, 1'b1, 1'b0);
      // R1: zero start, no alignment limit, above 32 bits
      run_case("zero", 64'h0, 64'h1_0000_0000, 64'h1_8000_0000, 4'd0, 1'b1, 1'b0);
      run_case("high", 64'h1_0000_0000, 64'h0, 64'h1_8000_0000, 4'd2, 1'b1, 1'b0);
      // R4 R6: needs nine windows
      run_case("budget", 64'h0, 64'h0, 64'h7f30000, 4'd0, 1'b1, 1'b0);
      // R4: exactly eight windows
      run_case("exact", 64'h0, 64'h0, 64'h7f10000, 4'd0, 1'b1, 1'b0);
      // R5 R6: start aligned only to 32 KiB
      run_case("small", 64'h10008000, 64'h0, 64'h100000, 4'd0, 1'b1, 1'b0);
      // R5: misaligned tail after progress
      run_case("tail", 64'h20000000, 64'h20000000, 64'h38000, 4'd4, 1'b1, 1'b0);
      // R8: zero size
      run_case("empty", 64'h40000000, 64'h0, 64'h0, 4'd5, 1'b1, 1'b0);
      // R7: invalid index
      run_case("void", 64'h40000000, 64'h0, 64'h100000, 4'd0, 1'b0, 1'b0);
      // R4: start index at budget end
      run_case("full", 64'h40000000, 64'h0, 64'h10000, 4'd8, 1'b1, 1'b0);
      run_case("fullzero", 64'h40000000, 64'h0, 64'h0, 4'd8, 1'b1, 1'b0);
      // R11: start pulse during run
      run_case("poke", 64'h80000000, 64'h9000_0000, 64'h300000, 4'd1, 1'b1, 1'b1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule